// File: doc/BRIEF.md
# Serial-Lookup Set-Associative Read Cache Controller

This block is a read-only cache that sits between a processor read port and a memory port that moves whole blocks. A processor address is split into a tag, a set index and a word offset. The set index picks one set of the line store directly. The ways of that set are then checked one per clock. A way-select counter steers a single multiplexer in front of a single tag comparator. The walk stops at the first valid way whose tag matches, and the addressed word of that line is returned.

When no way of the set matches, the controller asks memory for the whole block. The block address is the tag and the set index joined together, so a block lands in the set given by its block number modulo the number of sets. The returned block is written into the set together with its tag, and only then is the word given to the processor. The victim is the lowest-numbered empty way if there is one. Otherwise a per-set recency pointer chooses it. Only one request is in flight at a time.

Top module: `ssa_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` is 1, and `cpu_rvalid` and `mem_req` are 0. The first access to any address is therefore a miss.
- R2: The address layout is `{tag, set, offset}`. The low OFF_W bits are the word offset, the next SET_W bits are the set, and the top TAG_W bits are the tag. A line filled in one set never produces a hit for an address that maps to another set.
- R3: If the first matching valid way of the set is way k, `cpu_rvalid` rises k+1 clock edges after the accepting edge, with `cpu_hit`=1. `mem_req` stays 0 for the whole lookup.
- R4: The returned word at offset o is bits [o*WORD_W +: WORD_W] of the stored (or fetched) block.
- R5: On a miss, `mem_req` rises exactly WAYS edges after the accepting edge, with `mem_baddr` = `{tag, set}`. It stays high until an edge at which `mem_valid` is 1.
- R6: On the edge that samples `mem_valid`=1, the block is installed with its tag. At the same edge `cpu_rvalid` rises with `cpu_hit`=0 and the word selected from `mem_block`, and `mem_req` falls.
- R7: A fill goes to the lowest-numbered invalid way of the set when one exists.
- R8: When all ways are valid, the way named by the set's victim pointer is replaced. The pointer starts at way 0. On every hit or fill of way w, a pointer equal to w advances to w+1 (wrapping), so that with two ways the least recently used way is evicted.
- R9: A request is accepted only on an edge where `cpu_ready` is 1, which is only while idle. `cpu_req` and `cpu_addr` are ignored while a lookup or fill is in progress.
- R10: `cpu_rvalid` is a one-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Read request, taken when `cpu_ready` is 1 |
| cpu_addr | input | TAG_W+SET_W+OFF_W | Word address `{tag, set, offset}` |
| cpu_ready | output | 1 | Controller idle, can take a request |
| cpu_rvalid | output | 1 | One-cycle pulse, read data valid |
| cpu_rdata | output | WORD_W | Returned word |
| cpu_hit | output | 1 | With `cpu_rvalid`: 1 if served from the cache |
| mem_req | output | 1 | Block fetch request, held until answered |
| mem_baddr | output | TAG_W+SET_W | Block address `{tag, set}` |
| mem_valid | input | 1 | Block returned (one-cycle pulse) |
| mem_block | input | WORDS*WORD_W | Whole block, word 0 in the low bits |

## Verification
A wrong tag, valid bit or victim pointer shows up at the ports on a later access to the same set. It appears as a hit where a miss belongs, or the reverse, as a hit on the wrong way and so a wrong latency, or as a stale word. A reference model of every line and pointer in the bench catches this on the first response after the fault is exercised. A wrong way-select walk shows up at once as an off-by-some hit latency or a mistimed `mem_req`. That is why every response is checked for its latency, hit flag, data and fetch address, and not only for its data.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMP  = 2'd1,
        ST_FILL = 2'd2
    } ssa_state_e;

endpackage

// File: rtl/ssa_line_store.sv
module ssa_line_store #(
    parameter int SETS  = 2,
    parameter int WAYS  = 2,
    parameter int TAG_W = 2,
    parameter int BLK_W = 32,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    input  logic [WAY_W-1:0] rd_way,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [BLK_W-1:0] rd_block,
    output logic [WAYS-1:0]  set_valid,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [BLK_W-1:0] wr_block
);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][BLK_W-1:0]  blk;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.vld[wr_set][wr_way] = 1'b1;
            s_d.tag[wr_set][wr_way] = wr_tag;
            s_d.blk[wr_set][wr_way] = wr_block;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Way-select multiplexer: one line of the enabled set goes to the comparator.
    assign rd_valid  = s_q.vld[rd_set][rd_way];
    assign rd_tag    = s_q.tag[rd_set][rd_way];
    assign rd_block  = s_q.blk[rd_set][rd_way];
    assign set_valid = s_q.vld[rd_set];

    // R6
    fill_installs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (s_q.vld[$past(wr_set)][$past(wr_way)] &&
                   s_q.tag[$past(wr_set)][$past(wr_way)] == $past(wr_tag)));

endmodule

// File: rtl/ssa_way_walker.sv
module ssa_way_walker #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             line_valid,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic [WAY_W-1:0] way_sel,
    output logic             match,
    output logic             exhausted
);

    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    typedef struct packed {
        logic [WAY_W-1:0] sel;
    } walk_t;

    walk_t w_d, w_q;
    logic  last;

    // The single tag comparator.
    assign match     = active && line_valid && (line_tag == req_tag);
    assign last      = (w_q.sel == LAST_WAY);
    assign exhausted = active && !match && last;
    assign way_sel   = w_q.sel;

    always_comb begin
        w_d = w_q;
        if (!active || match || last) begin
            w_d.sel = '0;
        end else begin
            w_d.sel = w_q.sel + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    // R3
    walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !match && !last) |=> (way_sel == $past(way_sel) + 1'b1));

    // R3
    walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (way_sel == '0));

endmodule

// File: rtl/ssa_victim.sv
module ssa_victim #(
    parameter int SETS = 2,
    parameter int WAYS = 2,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_sel,
    input  logic [WAYS-1:0]  set_valid,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] victim
);

    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    typedef struct packed {
        logic [SETS-1:0][WAY_W-1:0] ptr;
    } repl_t;

    repl_t r_d, r_q;
    logic             any_free;
    logic [WAY_W-1:0] free_way;

    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_valid[w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
        victim = any_free ? free_way : r_q.ptr[set_sel];
    end

    always_comb begin
        r_d = r_q;
        if (touch_en && (r_q.ptr[set_sel] == touch_way)) begin
            r_d.ptr[set_sel] = (touch_way == LAST_WAY) ? '0 : touch_way + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R7
    free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&set_valid) |-> !set_valid[victim]);

    // R8
    ptr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_en && r_q.ptr[set_sel] == touch_way) |=>
            (r_q.ptr[$past(set_sel)] != $past(touch_way)) || (WAYS == 1));

endmodule

// File: rtl/ssa_cache_ctrl.sv
module ssa_cache_ctrl #(
    parameter int SETS   = 2,
    parameter int WAYS   = 2,
    parameter int TAG_W  = 2,
    parameter int WORDS  = 4,
    parameter int WORD_W = 8,
    localparam int SET_W   = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int OFF_W   = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int ADDR_W  = TAG_W + SET_W + OFF_W,
    localparam int BADDR_W = TAG_W + SET_W,
    localparam int BLK_W   = WORDS * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic [ADDR_W-1:0]  cpu_addr,
    output logic               cpu_ready,
    output logic               cpu_rvalid,
    output logic [WORD_W-1:0]  cpu_rdata,
    output logic               cpu_hit,
    output logic               mem_req,
    output logic [BADDR_W-1:0] mem_baddr,
    input  logic               mem_valid,
    input  logic [BLK_W-1:0]   mem_block
);

    import ssa_pkg::*;

    typedef struct packed {
        ssa_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              rvalid;
        logic [WORD_W-1:0] rdata;
        logic              hit;
        logic              mem_req;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic [TAG_W-1:0] req_tag;
    logic [SET_W-1:0] req_set;
    logic [OFF_W-1:0] req_off;
    logic             line_valid;
    logic [TAG_W-1:0] line_tag;
    logic [BLK_W-1:0] line_block;
    logic [WAYS-1:0]  set_valid;
    logic [WAY_W-1:0] way_sel;
    logic             match;
    logic             exhausted;
    logic [WAY_W-1:0] victim;
    logic             walk_active;
    logic             wr_en;
    logic             touch_en;
    logic [WAY_W-1:0] touch_way;

    assign req_tag     = c_q.addr[ADDR_W-1 -: TAG_W];
    assign req_set     = c_q.addr[OFF_W +: SET_W];
    assign req_off     = c_q.addr[OFF_W-1:0];
    assign walk_active = (c_q.st == ST_CMP);

    ssa_line_store #(
        .SETS (SETS),
        .WAYS (WAYS),
        .TAG_W(TAG_W),
        .BLK_W(BLK_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (req_set),
        .rd_way   (way_sel),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .rd_block (line_block),
        .set_valid(set_valid),
        .wr_en    (wr_en),
        .wr_set   (req_set),
        .wr_way   (victim),
        .wr_tag   (req_tag),
        .wr_block (mem_block)
    );

    ssa_way_walker #(
        .WAYS (WAYS),
        .TAG_W(TAG_W)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (walk_active),
        .line_valid(line_valid),
        .line_tag  (line_tag),
        .req_tag   (req_tag),
        .way_sel   (way_sel),
        .match     (match),
        .exhausted (exhausted)
    );

    ssa_victim #(
        .SETS(SETS),
        .WAYS(WAYS)
    ) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_sel  (req_set),
        .set_valid(set_valid),
        .touch_en (touch_en),
        .touch_way(touch_way),
        .victim   (victim)
    );

    always_comb begin
        c_d       = c_q;
        c_d.rvalid = 1'b0;
        c_d.hit    = 1'b0;
        wr_en      = 1'b0;
        touch_en   = 1'b0;
        touch_way  = way_sel;
        unique case (c_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    c_d.addr = cpu_addr;
                    c_d.st   = ST_CMP;
                end
            end
            ST_CMP: begin
                if (match) begin
                    c_d.rvalid = 1'b1;
                    c_d.hit    = 1'b1;
                    c_d.rdata  = line_block[req_off * WORD_W +: WORD_W];
                    touch_en   = 1'b1;
                    c_d.st     = ST_IDLE;
                end else if (exhausted) begin
                    c_d.mem_req = 1'b1;
                    c_d.st      = ST_FILL;
                end
            end
            ST_FILL: begin
                touch_way = victim;
                if (mem_valid) begin
                    wr_en       = 1'b1;
                    touch_en    = 1'b1;
                    c_d.rvalid  = 1'b1;
                    c_d.rdata   = mem_block[req_off * WORD_W +: WORD_W];
                    c_d.mem_req = 1'b0;
                    c_d.st      = ST_IDLE;
                end
            end
            default: begin
                c_d.st      = ST_IDLE;
                c_d.mem_req = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign cpu_ready  = (c_q.st == ST_IDLE);
    assign cpu_rvalid = c_q.rvalid;
    assign cpu_rdata  = c_q.rdata;
    assign cpu_hit    = c_q.hit;
    assign mem_req    = c_q.mem_req;
    assign mem_baddr  = c_q.addr[ADDR_W-1:OFF_W];

    // R5
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> mem_req);

    // R10
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |=> !cpu_rvalid);

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |=> $stable(c_q.addr));

    // R3
    idle_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

    // R6
    fill_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid) |=> (cpu_rvalid && !cpu_hit && !mem_req));

endmodule

// File: tb/ssa_cache_ctrl_bench.sv
module ssa_cache_ctrl_bench;

    localparam int SETS    = 2;
    localparam int WAYS    = 2;
    localparam int TAG_W   = 2;
    localparam int WORDS   = 4;
    localparam int WORD_W  = 8;
    localparam int SET_W   = 1;
    localparam int OFF_W   = 2;
    localparam int ADDR_W  = TAG_W + SET_W + OFF_W;
    localparam int BADDR_W = TAG_W + SET_W;
    localparam int BLK_W   = WORDS * WORD_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cpu_req = 1'b0;
    logic [ADDR_W-1:0]  cpu_addr = '0;
    logic               cpu_ready;
    logic               cpu_rvalid;
    logic [WORD_W-1:0]  cpu_rdata;
    logic               cpu_hit;
    logic               mem_req;
    logic [BADDR_W-1:0] mem_baddr;
    logic               mem_valid = 1'b0;
    logic [BLK_W-1:0]   mem_block = '0;

    int compared = 0;
    int mismatched = 0;
    int last_d = 0;
    bit done = 1'b0;

    bit ref_vld [SETS][WAYS];
    int ref_tag [SETS][WAYS];
    int ref_ptr [SETS];

    always #10 clk = ~clk;

    ssa_cache_ctrl #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .WORDS(WORDS), .WORD_W(WORD_W)
    ) u_ssa_cache_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .cpu_hit(cpu_hit), .mem_req(mem_req), .mem_baddr(mem_baddr),
        .mem_valid(mem_valid), .mem_block(mem_block)
    );

    function automatic logic [WORD_W-1:0] word_of(int baddr, int off);
        return WORD_W'((baddr * 53 + off * 29 + 7) ^ (baddr << 4));
    endfunction

    function automatic logic [BLK_W-1:0] block_of(int baddr);
        logic [BLK_W-1:0] b;
        for (int o = 0; o < WORDS; o++) b[o*WORD_W +: WORD_W] = word_of(baddr, o);
        return b;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Memory responder: answers each block fetch after 0..3 cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && !mem_valid) begin
                int d;
                d = int'($urandom % 4);
                last_d = d;
                repeat (d) @(negedge clk);
                mem_block = block_of(int'(mem_baddr));
                mem_valid = 1'b1;
                @(negedge clk);
                mem_valid = 1'b0;
            end
        end
    end

    task automatic do_req(input int a, input bit noise, input string rq);
        int tg, st, off, hw, lat, seen, baddr_obs, exp_lat, vic;
        bit busy_ok;
        tg  = a >> (SET_W + OFF_W);
        st  = (a >> OFF_W) % SETS;
        off = a % WORDS;
        hw  = -1;
        for (int w = WAYS - 1; w >= 0; w--)
            if (ref_vld[st][w] && ref_tag[st][w] == tg) hw = w;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req  = 1'b1;
        cpu_addr = ADDR_W'(a);
        @(posedge clk);
        @(negedge clk);
        if (noise) cpu_addr = ADDR_W'(a ^ 5'b10100);
        else cpu_req = 1'b0;
        lat = 0; seen = -1; baddr_obs = 0; busy_ok = 1'b1;
        while (!cpu_rvalid && lat < 60) begin
            if (mem_req && seen < 0) begin
                seen = lat;
                baddr_obs = int'(mem_baddr);
            end
            if (cpu_ready) busy_ok = 1'b0;
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        cpu_req = 1'b0;
        // R9: no idle window while busy
        chk(busy_ok, "R9", "ready low while busy", int'(busy_ok), 1);
        // hit/miss decision
        chk(cpu_hit == (hw >= 0), rq, "hit flag", int'(cpu_hit), int'(hw >= 0));
        // R4: returned word
        chk(cpu_rdata == word_of(a >> OFF_W, off), "R4", "read data",
            int'(cpu_rdata), int'(word_of(a >> OFF_W, off)));
        if (hw >= 0) begin
            // R3: serial compare latency
            chk(lat == hw + 1, "R3", "hit latency", lat, hw + 1);
            chk(seen < 0, "R3", "no fetch on hit", seen, -1);
            if (ref_ptr[st] == hw) ref_ptr[st] = (hw + 1) % WAYS;
        end else begin
            exp_lat = WAYS + 1 + last_d;
            // R5: fetch timing and block address
            chk(seen == WAYS, "R5", "mem_req edge", seen, WAYS);
            chk(baddr_obs == (a >> OFF_W), "R5", "block address", baddr_obs, a >> OFF_W);
            // R6: answer after the fill
            chk(lat == exp_lat, "R6", "miss latency", lat, exp_lat);
            vic = -1;
            for (int w = WAYS - 1; w >= 0; w--) if (!ref_vld[st][w]) vic = w;
            if (vic < 0) vic = ref_ptr[st];
            ref_vld[st][vic] = 1'b1;
            ref_tag[st][vic] = tg;
            if (ref_ptr[st] == vic) ref_ptr[st] = (vic + 1) % WAYS;
        end
        @(negedge clk);
        // R10: single pulse
        chk(!cpu_rvalid, "R10", "rvalid pulse width", int'(cpu_rvalid), 0);
    endtask

    function automatic int mk(int tg, int st, int off);
        return (tg << (SET_W + OFF_W)) | (st << OFF_W) | off;
    endfunction

    initial begin
        void'($urandom(32'd1234));
        for (int s = 0; s < SETS; s++) begin
            ref_ptr[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                ref_vld[s][w] = 1'b0;
                ref_tag[s][w] = 0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cpu_ready == 1'b1, "R1", "ready after reset", int'(cpu_ready), 1);
        chk(cpu_rvalid == 1'b0, "R1", "rvalid after reset", int'(cpu_rvalid), 0);
        chk(mem_req == 1'b0, "R1", "mem_req after reset", int'(mem_req), 0);

        do_req(mk(0, 0, 1), 1'b0, "R1");   // cold miss, fills way 0
        do_req(mk(0, 0, 3), 1'b0, "R3");   // hit way 0
        do_req(mk(1, 0, 0), 1'b0, "R7");   // miss, fills free way 1
        do_req(mk(1, 0, 2), 1'b0, "R3");   // hit way 1, latency 2
        do_req(mk(0, 1, 1), 1'b0, "R2");   // same tag, other set: miss
        do_req(mk(0, 0, 0), 1'b0, "R8");   // hit way 0, pointer -> way 1
        do_req(mk(2, 0, 3), 1'b1, "R8");   // evicts way 1; cpu_req held busy (R9)
        do_req(mk(1, 0, 1), 1'b0, "R8");   // evicted tag misses again
        do_req(mk(2, 0, 2), 1'b0, "R9");   // noise address was not installed
        do_req(mk(3, 1, 2), 1'b0, "R7");   // set 1 second free way

        for (int i = 0; i < 300; i++) begin
            do_req(int'($urandom % (1 << ADDR_W)), ($urandom % 8) == 0, "R8");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule